// File: doc/BRIEF.md
# Triggered Circular Sample Recorder

This block is the capture core of an acquisition device. Once a start command arms it, it writes every valid 16-bit input sample into a 4096-entry memory. The write address is a plain binary counter that wraps, so the memory always holds the most recent history.

A masked comparator looks at every valid sample and drives a one-cycle match pulse. The first match seen while armed becomes the trigger. The block records the trigger sample's address and then stores a programmed number of further samples. After that it stops writing and raises a done flag, and the memory holds the history before the trigger and after it. A stop command ends sampling at once.

The buffer is unloaded through a read port that only works while no sampling is in progress. Read data appears one cycle after the request.

The controller has four states: `ST_IDLE`, `ST_ARMED`, `ST_POST` and `ST_DONE`. Its transitions are:
- Any state goes to `ST_ARMED` on a start command.
- `ST_ARMED` goes to `ST_POST` on a trigger when the post count is non-zero.
- `ST_ARMED` goes to `ST_DONE` on a trigger when the post count is zero.
- `ST_POST` goes to `ST_DONE` when the last post-trigger sample is stored.
- `ST_ARMED` and `ST_POST` go to `ST_IDLE` on a stop command.
- `ST_IDLE` and `ST_DONE` otherwise hold.

Top module: `trig_capture`

## Requirements
- R1: After reset `done_o`, `match_o`, `trig_addr_o` and `rd_data` are all zero and the block is idle, so no sample is written.
- R2: `match_o` is high in the cycle after a valid sample whose bits equal `cfg_word` at every position where `cfg_mask` has a 1; positions with a mask bit of 0 are ignored, so an all-zero mask matches every valid sample. This holds in every state.
- R3: `cmd_start` clears `done_o`, resets the write address to 0 and arms the block. Each valid sample taken while sampling (armed or post-trigger) is stored at the current write address, and the address then advances by one.
- R4: The first matching valid sample while armed is stored, and its address appears on `trig_addr_o` in the following cycle.
- R5: After the trigger sample, exactly `cfg_post` further valid samples are stored, where `cfg_post` is sampled at the trigger. `done_o` rises in the cycle after the last of them. With `cfg_post` = 0, `done_o` rises in the cycle after the trigger sample itself.
- R6: The write address wraps from 4095 to 0, so a history longer than 4096 samples overwrites the oldest entries.
- R7: After the trigger, further matches do not move `trig_addr_o`. Once `done_o` is high, samples are not written, and `done_o` and `trig_addr_o` hold until the next `cmd_start`.
- R8: `cmd_stop` while sampling halts capture: no sample is written in that cycle or later, `done_o` stays low, and `trig_addr_o` is unchanged. `cmd_stop` while idle or done has no effect.
- R9: A sample presented in a cycle that carries a command is not stored and cannot trigger. `cmd_start` takes priority over `cmd_stop` in the same cycle.
- R10: `rd_en` while not sampling loads `rd_data` with the memory word at `rd_addr` in the next cycle. While sampling, or with `rd_en` low, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | 16 | Incoming sample |
| smp_valid | input | 1 | Sample strobe |
| cfg_word | input | 16 | Comparison word |
| cfg_mask | input | 16 | Comparison enable per bit (1 = compare) |
| cfg_post | input | 12 | Number of samples stored after the trigger |
| cmd_start | input | 1 | Start sampling from address 0 |
| cmd_stop | input | 1 | Stop sampling immediately |
| match_o | output | 1 | Registered comparator result |
| done_o | output | 1 | Post-trigger capture complete |
| trig_addr_o | output | 12 | Address of the trigger sample |
| rd_en | input | 1 | Read request |
| rd_addr | input | 12 | Read address |
| rd_data | output | 16 | Read data, valid one cycle after request |

## Verification
The comparator is driven with random words under three masks: all ones, a partial nibble mask, and all zeros. Samples are forced to agree only on the unmasked bits, which separates a correct mask from one that compares every bit or none. Captures are run with a pre-trigger history long enough to wrap the address, with a zero post count, and with stop commands while armed and while counting. Each of these tells apart a different exit from the sampling states. A final random phase mixes starts, stops, triggers and sample gaps against a bench model. Readback of a full wrapped buffer, and of addresses that a halted or finished capture must not touch, shows where writing actually stopped.

// File: rtl/trig_capture_pkg.sv
package trig_capture_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_t;

endpackage

// File: rtl/tc_word_match.sv
module tc_word_match #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] mask,
    output logic              hit
);
    logic [DATA_W-1:0] bit_ok;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign bit_ok[i] = ~mask[i] | (data[i] ~^ word[i]);
    end

    assign hit = &bit_ok;

endmodule

// File: rtl/tc_sample_ram.sv
module tc_sample_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4096,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/tc_ctrl.sv
module tc_ctrl
    import trig_capture_pkg::*;
#(
    parameter int DEPTH = 4096,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              hit,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic [ADDR_W-1:0] cfg_post,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] trig_addr,
    output logic              done,
    output logic              sampling
);
    cap_state_t        st, st_nxt;
    logic [ADDR_W-1:0] remain;
    logic              clr_addr, load_trig, dec_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // next state and control outputs
    always_comb begin
        st_nxt    = st;
        wr_en     = 1'b0;
        clr_addr  = 1'b0;
        load_trig = 1'b0;
        dec_cnt   = 1'b0;
        if (cmd_start) begin
            st_nxt   = ST_ARMED;
            clr_addr = 1'b1;
        end else begin
            unique case (st)
                ST_IDLE: st_nxt = ST_IDLE;
                ST_ARMED: begin
                    if (cmd_stop) begin
                        st_nxt = ST_IDLE;
                    end else if (smp_valid) begin
                        wr_en = 1'b1;
                        if (hit) begin
                            load_trig = 1'b1;
                            st_nxt    = (cfg_post == '0) ? ST_DONE : ST_POST;
                        end
                    end
                end
                ST_POST: begin
                    if (cmd_stop) begin
                        st_nxt = ST_IDLE;
                    end else if (smp_valid) begin
                        wr_en   = 1'b1;
                        dec_cnt = 1'b1;
                        if (remain == ADDR_W'(1)) begin
                            st_nxt = ST_DONE;
                        end
                    end
                end
                ST_DONE: st_nxt = ST_DONE;
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // address, trigger and post counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr   <= '0;
            trig_addr <= '0;
            remain    <= '0;
        end else begin
            if (clr_addr) begin
                wr_addr <= '0;
            end else if (wr_en) begin
                wr_addr <= wr_addr + ADDR_W'(1);
            end
            if (load_trig) begin
                trig_addr <= wr_addr;
                remain    <= cfg_post;
            end else if (dec_cnt) begin
                remain <= remain - ADDR_W'(1);
            end
        end
    end

    assign done     = (st == ST_DONE);
    assign sampling = (st == ST_ARMED) || (st == ST_POST);

endmodule

// File: rtl/trig_capture.sv
module trig_capture #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4096,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] cfg_word,
    input  logic [DATA_W-1:0] cfg_mask,
    input  logic [ADDR_W-1:0] cfg_post,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    output logic              match_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] trig_addr_o,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              hit;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic              sampling;

    tc_word_match #(.DATA_W(DATA_W)) u_match (
        .data (smp_data),
        .word (cfg_word),
        .mask (cfg_mask),
        .hit  (hit)
    );

    tc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .hit       (hit),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .cfg_post  (cfg_post),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .trig_addr (trig_addr_o),
        .done      (done_o),
        .sampling  (sampling)
    );

    tc_sample_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (smp_data),
        .rd_en   (rd_en && !sampling),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_o <= 1'b0;
        end else begin
            match_o <= smp_valid && hit;
        end
    end

endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] smp_data,
    input logic              smp_valid,
    input logic [DATA_W-1:0] cfg_word,
    input logic [DATA_W-1:0] cfg_mask,
    input logic              cmd_start,
    input logic              cmd_stop,
    input logic              match_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] trig_addr_o,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              sampling
);
    assert_match_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (((smp_data ^ cfg_word) & cfg_mask) == '0)) |=> match_o);

    assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !done_o);

    assert_trig_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(trig_addr_o));

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cmd_start) |=> (done_o && $stable(trig_addr_o)));

    assert_stop_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_start && !done_o) |=> !done_o);

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_rd_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sampling |=> $stable(rd_data));

    assert_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && sampling));

endmodule

bind trig_capture trig_capture_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_data    (smp_data),
    .smp_valid   (smp_valid),
    .cfg_word    (cfg_word),
    .cfg_mask    (cfg_mask),
    .cmd_start   (cmd_start),
    .cmd_stop    (cmd_stop),
    .match_o     (match_o),
    .done_o      (done_o),
    .trig_addr_o (trig_addr_o),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .sampling    (sampling)
);

// File: tb/trig_capture_test.sv
`timescale 1ns/1ps
module trig_capture_test;
    localparam int DW = 16;
    localparam int AW = 12;
    localparam int DEP = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] cfg_word = '0;
    logic [DW-1:0] cfg_mask = '0;
    logic [AW-1:0] cfg_post = '0;
    logic          cmd_start = 1'b0;
    logic          cmd_stop = 1'b0;
    logic          match_o, done_o;
    logic [AW-1:0] trig_addr_o;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;

    trig_capture uut (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
        .cfg_word(cfg_word), .cfg_mask(cfg_mask), .cfg_post(cfg_post),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .match_o(match_o),
        .done_o(done_o), .trig_addr_o(trig_addr_o), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model: 0 idle, 1 armed, 2 post, 3 done
    int            m_st = 0;
    int            m_wa = 0;
    int            m_rem = 0;
    logic [AW-1:0] m_trig = '0;
    logic          m_match = 1'b0;
    logic [DW-1:0] m_rd = '0;
    logic [DW-1:0] sh [DEP];
    bit            sh_ok [DEP];

    function automatic bit is_hit(logic [DW-1:0] d);
        return ((d ^ cfg_word) & cfg_mask) == '0;
    endfunction

    function automatic logic [DW-1:0] miss_word();
        logic [DW-1:0] d = DW'($urandom);
        if (is_hit(d)) d = d ^ (cfg_mask & (~cfg_mask + 1'b1));
        return d;
    endfunction

    function automatic logic [DW-1:0] hit_word();
        return (DW'($urandom) & ~cfg_mask) | (cfg_word & cfg_mask);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic step(bit v, logic [DW-1:0] d, bit st, bit sp);
        bit h;
        @(negedge clk);
        smp_valid = v; smp_data = d; cmd_start = st; cmd_stop = sp; rd_en = 1'b0;
        @(posedge clk);
        h = is_hit(d);
        m_match = v && h;
        if (st) begin
            m_st = 1; m_wa = 0;
        end else if ((m_st == 1 || m_st == 2) && sp) begin
            m_st = 0;
        end else if (m_st == 1 && v) begin
            sh[m_wa] = d; sh_ok[m_wa] = 1;
            if (h) begin
                m_trig = AW'(m_wa); m_rem = int'(cfg_post);
                m_st = (cfg_post == 0) ? 3 : 2;
            end
            m_wa = (m_wa + 1) % DEP;
        end else if (m_st == 2 && v) begin
            sh[m_wa] = d; sh_ok[m_wa] = 1;
            m_wa = (m_wa + 1) % DEP;
            m_rem--;
            if (m_rem == 0) m_st = 3;
        end
        #2;
        check("R2 match", match_o, m_match);
        check("R5 done", done_o, m_st == 3);
        check("R4 trig_addr", trig_addr_o, m_trig);
        @(negedge clk);
        smp_valid = 1'b0; cmd_start = 1'b0; cmd_stop = 1'b0;
    endtask

    task automatic rd(int a, string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(a); smp_valid = 1'b0;
        @(posedge clk);
        if (!(m_st == 1 || m_st == 2)) m_rd = sh[a];
        #2;
        check(tag, rd_data, m_rd);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < DEP; i++) sh_ok[i] = 0;
        #20;
        check("R1 done reset", done_o, 0);
        check("R1 match reset", match_o, 0);
        check("R1 trig reset", trig_addr_o, 0);
        check("R1 rd reset", rd_data, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: comparator in idle under three masks
        cfg_word = 16'hA5A5; cfg_mask = 16'hFFFF;
        for (int i = 0; i < 20; i++) step(1, (i % 2) ? hit_word() : miss_word(), 0, 0);
        cfg_mask = 16'hF0F0;
        for (int i = 0; i < 20; i++) step(1, (i % 2) ? hit_word() : miss_word(), 0, 0);
        cfg_mask = 16'h0000;
        for (int i = 0; i < 5; i++) step(1, DW'($urandom), 0, 0);
        step(0, 16'hA5A5, 0, 0);   // R2: no match without valid
        // R1: idle after reset writes nothing: address 0 stays unwritten until start
        cfg_mask = 16'hFFFF; cfg_post = 12'd100;

        // R9: sample in start cycle not stored, no trigger
        step(1, 16'hA5A5, 1, 0);
        check("R9 no trigger in cmd cycle", done_o, 0);
        // R6: history wraps
        for (int i = 0; i < 5000; i++) step(1, miss_word(), 0, 0);
        check("R6 wrap address", m_wa, 5000 % DEP);
        step(1, 16'hA5A5, 0, 0);
        check("R4 trigger address", trig_addr_o, AW'(5000 % DEP));
        for (int i = 0; i < 99; i++) step(1, (i == 10) ? 16'hA5A5 : miss_word(), 0, 0);
        check("R5 not yet done", done_o, 0);
        step(1, miss_word(), 0, 0);
        check("R5 done after post", done_o, 1);
        for (int i = 0; i < 12; i++) rd(int'($urandom) % DEP, "R10 readback");
        rd(5000 % DEP, "R4 trigger sample");
        rd((5000 + 100) % DEP, "R6 last post sample");
        rd((5000 + 101) % DEP, "R6 oldest history");
        rd(DEP - 1, "R6 wrap boundary");
        // R7: after done, nothing written, trig/done hold
        for (int i = 0; i < 5; i++) step(1, 16'hA5A5, 0, 0);
        step(1, miss_word(), 0, 1);   // stop in done: no effect (R8)
        check("R7 done holds", done_o, 1);
        rd(m_wa, "R7 no write after done");
        rd((m_wa + 1) % DEP, "R7 no write after done");

        // R3/R8: restart, then stop while armed
        step(0, 0, 1, 0);
        check("R3 start clears done", done_o, 0);
        for (int i = 0; i < 10; i++) step(1, miss_word(), 0, 0);
        step(1, 16'hA5A5, 0, 1);
        check("R8 stop keeps trig", trig_addr_o, AW'(5000 % DEP));
        for (int i = 0; i < 4; i++) step(1, 16'hA5A5, 0, 0);
        check("R8 no done after stop", done_o, 0);
        rd(0, "R3 write from address 0");
        rd(9, "R3 sample order");
        rd(10, "R8 stop cycle not written");
        rd(11, "R8 no write after stop");

        // R9: start+stop together arms; R10 read blocked while sampling
        step(0, 0, 1, 1);
        step(1, 16'h1234, 0, 0);
        rd(0, "R10 read blocked while sampling");
        cfg_post = 12'd0;
        step(1, 16'hA5A5, 0, 0);
        check("R5 zero post done", done_o, 1);
        check("R4 trig at 1", trig_addr_o, 1);
        rd(0, "R9 start wins over stop");
        rd(2, "R5 zero post stops writing");

        // R8: stop while counting post samples
        cfg_post = 12'd3;
        step(0, 0, 1, 0);
        step(1, 16'hA5A5, 0, 0);
        step(1, miss_word(), 0, 0);
        step(1, miss_word(), 0, 1);
        step(1, miss_word(), 0, 0);
        check("R8 stop in post", done_o, 0);
        rd(2, "R8 stop in post not written");

        // mixed random phase
        cfg_mask = 16'h00FF; cfg_word = 16'h003C;
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom % 100);
            if (r < 3) begin
                cfg_post = AW'($urandom % 8);
                step(0, 0, 1, 0);
            end else if (r < 5) begin
                step(1, hit_word(), 0, 1);
            end else if (r < 15) begin
                step(1, hit_word(), 0, 0);
            end else begin
                step(r < 80, miss_word(), 0, 0);
            end
        end
        step(0, 0, 0, 1);
        for (int i = 0; i < 16; i++) begin
            int a = int'($urandom % 64);
            if (sh_ok[a]) rd(a, "R3 random readback");
        end
        summary();
    end
endmodule